// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block turns two kinds of host request into the command traffic that a 16-bit parallel NOR flash expects. An erase request names a first and a last sector. A program request names one halfword address and the data to store there. The block drives a simple memory-style bus to the flash: word address, write data, read data, a write strobe and a read strobe. For each operation it writes the fixed command bytes and then polls the device status word until bit 7 (ready) is set. It enforces a cycle-count timeout on every poll phase and turns error bits in the status word into distinct result codes. When the operation is over it raises a one-cycle done pulse together with a 3-bit result code.

Requests use a valid/ready handshake. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the block is idle. It drops on the cycle after acceptance and stays low up to and including the done cycle, so the host must hold its request until it is taken. A valid asserted while `req_ready` is low has no effect. Protect bits arrive as a static vector with one bit per sector. Sector `s` begins at word address `s << SECT_SHIFT`.

The read strobe `fl_re` is asserted for one cycle. The device must present read data on `fl_rdata` by the next rising edge, and the block samples it there.

Result codes: 0 ok, 1 invalid range, 2 protected, 3 timeout, 4 not erased, 5 voltage error, 6 device protect error, 7 programming error.

Top module: `flseq_ctrl`

## Requirements
- R1: An erase request whose first sector is greater than its last sector ends with result 1 and issues no bus write.
- R2: An erase request whose range contains any sector with its protect bit set ends with result 2 and issues no bus write. Protect bits outside the range have no effect.
- R3: For each sector in the range, the block writes 0x20 and then 0xD0 to the sector start address (sector index shifted left by SECT_SHIFT). It then reads that address until status bit 7 is set.
- R4: After each sector becomes ready, the block writes 0x50 and then 0xFF to the same address. Sectors are handled in ascending order. The erase ends with result 0 when the last sector is done.
- R5: If the erase poll sees bit 7 still clear after ERS_TO cycles, the block writes 0xB0 and then 0xFF, skips all later sectors and ends with result 3.
- R6: A program request first reads the target word. If (old AND new) differs from new, the request ends with result 4 and issues no bus write.
- R7: Otherwise the block writes 0x50, 0x40 and the data word to the target address and polls until bit 7 is set. With no error bits set, it writes 0xFF and ends with result 0.
- R8: If the program poll sees bit 7 still clear after PRG_TO cycles, the block writes 0xB0 and then 0xFF and ends with result 3.
- R9: When a program poll finds the device ready, the status error bits are decoded in this priority: bit 3 gives result 5, then bit 1 gives result 6, then bit 4 gives result 7. Each error ends with a 0xFF write.
- R10: The timeout count restarts at each sector's erase command, so a multi-sector erase whose total time exceeds ERS_TO still succeeds when each sector alone is within the limit.
- R11: `busy` is high and `req_ready` is low from acceptance through the done cycle. Requests presented in that window are ignored. `done` is high for exactly one cycle per accepted request.
- R12: `fl_we` and `fl_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_prog | input | 1 | 1 = program a halfword, 0 = erase a sector range |
| req_first | input | SW | First sector to erase |
| req_last | input | SW | Last sector to erase |
| req_addr | input | AW | Word address to program |
| req_data | input | 16 | Halfword to program |
| prot_map | input | NSECT | Per-sector protect bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code, valid while done is high |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | 16 | Flash write data |
| fl_rdata | input | 16 | Flash read data, valid on the edge after fl_re |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |

## Verification
The assertions check the properties that hold on every cycle. The two strobes never overlap. Done lasts exactly one cycle, and busy stays high until done. An invalid range goes straight to done without a write. Every ok or timeout completion is preceded by a 0xFF write. A cleared timer is never reported as expired. The bench scenarios show the rest: the exact order of command writes and addresses for each path, protect and not-erased rejection, how error bits are ranked, and that the timer restarts per sector. These need a device model whose timing and status word the bench controls.

// File: rtl/flseq_pkg.sv
package flseq_pkg;
  localparam int FL_DW = 16;

  localparam logic [FL_DW-1:0] CMD_ERS_SETUP = 16'h0020;
  localparam logic [FL_DW-1:0] CMD_ERS_CONF  = 16'h00D0;
  localparam logic [FL_DW-1:0] CMD_CLR_STAT  = 16'h0050;
  localparam logic [FL_DW-1:0] CMD_PRG_SETUP = 16'h0040;
  localparam logic [FL_DW-1:0] CMD_SUSPEND   = 16'h00B0;
  localparam logic [FL_DW-1:0] CMD_READ_ARR  = 16'h00FF;

  typedef enum logic [2:0] {
    RC_OK      = 3'd0,
    RC_INVAL   = 3'd1,
    RC_PROT    = 3'd2,
    RC_TIMEOUT = 3'd3,
    RC_NOTERAS = 3'd4,
    RC_VOLT    = 3'd5,
    RC_DEVPROT = 3'd6,
    RC_PRGERR  = 3'd7
  } rc_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ECHK, S_ESET, S_ECONF, S_POLL, S_WAIT, S_ECLR, S_ENRA,
    S_SUSP, S_FINRA, S_DONE, S_PRD, S_PCHK, S_PCLR, S_PSET, S_PDAT
  } st_e;
endpackage

// File: rtl/flseq_timer.sv
module flseq_timer #(
  parameter int ERS_TO = 1000000,
  parameter int PRG_TO = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sel_ers,
  output logic expired
);
  localparam int MAXTO = (ERS_TO > PRG_TO) ? ERS_TO : PRG_TO;
  localparam int TW    = $clog2(MAXTO + 2);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (cnt != '1) cnt <= cnt + 1'b1;
  end

  assign expired = cnt >= (sel_ers ? TW'(ERS_TO) : TW'(PRG_TO));

  a_r10_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !expired);
  a_r10_stays_expired: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clr && $stable(sel_ers)) |=> expired);
endmodule

// File: rtl/flseq_range_prot.sv
module flseq_range_prot #(
  parameter int NSECT = 8,
  parameter int SW    = 3
) (
  input  logic [SW-1:0]    first,
  input  logic [SW-1:0]    last,
  input  logic [NSECT-1:0] prot_map,
  output logic             hit
);
  logic [NSECT-1:0] in_rng;

  for (genvar i = 0; i < NSECT; i++) begin : g_sec
    assign in_rng[i] = prot_map[i] && (SW'(i) >= first) && (SW'(i) <= last);
  end

  assign hit = |in_rng;
endmodule

// File: rtl/flseq_stat_decode.sv
module flseq_stat_decode
  import flseq_pkg::*;
(
  input  logic [FL_DW-1:0] stat,
  output rc_e              code
);
  always_comb begin
    if (stat[3])      code = RC_VOLT;
    else if (stat[1]) code = RC_DEVPROT;
    else if (stat[4]) code = RC_PRGERR;
    else              code = RC_OK;
  end
endmodule

// File: rtl/flseq_ctrl.sv
module flseq_ctrl
  import flseq_pkg::*;
#(
  parameter int AW         = 16,
  parameter int NSECT      = 8,
  parameter int SECT_SHIFT = 12,
  parameter int ERS_TO     = 1000000,
  parameter int PRG_TO     = 10000,
  localparam int SW        = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_prog,
  input  logic [SW-1:0]    req_first,
  input  logic [SW-1:0]    req_last,
  input  logic [AW-1:0]    req_addr,
  input  logic [FL_DW-1:0] req_data,
  input  logic [NSECT-1:0] prot_map,
  output logic             busy,
  output logic             done,
  output logic [2:0]       result,
  output logic [AW-1:0]    fl_addr,
  output logic [FL_DW-1:0] fl_wdata,
  input  logic [FL_DW-1:0] fl_rdata,
  output logic             fl_we,
  output logic             fl_re
);
  st_e              st;
  rc_e              rc_q, dec_code;
  logic [SW-1:0]    cur_sec, last_sec;
  logic             is_prog, prot_hit, tmo, tmr_clr;
  logic [AW-1:0]    addr_q;
  logic [FL_DW-1:0] data_q;

  flseq_range_prot #(.NSECT(NSECT), .SW(SW)) u_prot (
    .first(cur_sec), .last(last_sec), .prot_map(prot_map), .hit(prot_hit));

  flseq_stat_decode u_dec (.stat(fl_rdata), .code(dec_code));

  assign tmr_clr = (st == S_ESET) || (st == S_PCLR);

  flseq_timer #(.ERS_TO(ERS_TO), .PRG_TO(PRG_TO)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .sel_ers(!is_prog), .expired(tmo));

  function automatic logic [AW-1:0] sect_base(input logic [SW-1:0] s);
    return AW'(s) << SECT_SHIFT;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rc_q     <= RC_OK;
      cur_sec  <= '0;
      last_sec <= '0;
      is_prog  <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          is_prog  <= req_prog;
          cur_sec  <= req_first;
          last_sec <= req_last;
          addr_q   <= req_addr;
          data_q   <= req_data;
          st       <= req_prog ? S_PRD : S_ECHK;
        end
        S_ECHK: begin
          if (cur_sec > last_sec) begin
            rc_q <= RC_INVAL;
            st   <= S_DONE;
          end else if (prot_hit) begin
            rc_q <= RC_PROT;
            st   <= S_DONE;
          end else begin
            addr_q <= sect_base(cur_sec);
            st     <= S_ESET;
          end
        end
        S_ESET:  st <= S_ECONF;
        S_ECONF: st <= S_POLL;
        S_POLL:  st <= S_WAIT;
        S_WAIT: begin
          if (fl_rdata[7]) begin
            if (is_prog) begin
              rc_q <= dec_code;
              st   <= S_FINRA;
            end else begin
              st <= S_ECLR;
            end
          end else if (tmo) begin
            rc_q <= RC_TIMEOUT;
            st   <= S_SUSP;
          end else begin
            st <= S_POLL;
          end
        end
        S_ECLR: st <= S_ENRA;
        S_ENRA: begin
          if (cur_sec == last_sec) begin
            rc_q <= RC_OK;
            st   <= S_DONE;
          end else begin
            cur_sec <= cur_sec + 1'b1;
            addr_q  <= sect_base(cur_sec + 1'b1);
            st      <= S_ESET;
          end
        end
        S_SUSP:  st <= S_FINRA;
        S_FINRA: st <= S_DONE;
        S_DONE:  st <= S_IDLE;
        S_PRD:   st <= S_PCHK;
        S_PCHK: begin
          if ((fl_rdata & data_q) != data_q) begin
            rc_q <= RC_NOTERAS;
            st   <= S_DONE;
          end else begin
            st <= S_PCLR;
          end
        end
        S_PCLR: st <= S_PSET;
        S_PSET: st <= S_PDAT;
        S_PDAT: st <= S_POLL;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    fl_we    = 1'b1;
    fl_re    = 1'b0;
    fl_wdata = '0;
    case (st)
      S_ESET:              fl_wdata = CMD_ERS_SETUP;
      S_ECONF:             fl_wdata = CMD_ERS_CONF;
      S_ECLR, S_PCLR:      fl_wdata = CMD_CLR_STAT;
      S_ENRA, S_FINRA:     fl_wdata = CMD_READ_ARR;
      S_SUSP:              fl_wdata = CMD_SUSPEND;
      S_PSET:              fl_wdata = CMD_PRG_SETUP;
      S_PDAT:              fl_wdata = data_q;
      S_POLL, S_PRD: begin fl_we = 1'b0; fl_re = 1'b1; end
      default:             fl_we = 1'b0;
    endcase
  end

  assign fl_addr   = addr_q;
  assign req_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign result    = rc_q;

  a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  a_r1_inval_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ECHK && cur_sec > last_sec) |=> (done && result == RC_INVAL && !fl_we));
  a_r8_timeout_ends_ra: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RC_TIMEOUT) |-> ($past(fl_we) && $past(fl_wdata) == CMD_READ_ARR));
  a_r7_ok_ends_ra: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RC_OK) |-> ($past(fl_we) && $past(fl_wdata) == CMD_READ_ARR));
endmodule

// File: tb/flseq_ctrl_test.sv
module flseq_ctrl_test;
  localparam int AW = 16, NSECT = 8, SHIFT = 12, SW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 1'b0, req_prog = 1'b0;
  logic [SW-1:0] req_first = '0, req_last = '0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_data = '0, fl_rdata = '0, fl_wdata;
  logic [NSECT-1:0] prot_map = '0;
  logic req_ready, busy, done, fl_we, fl_re;
  logic [2:0] result;
  logic [AW-1:0] fl_addr;

  flseq_ctrl #(.AW(AW), .NSECT(NSECT), .SECT_SHIFT(SHIFT), .ERS_TO(40), .PRG_TO(20)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_prog(req_prog), .req_first(req_first), .req_last(req_last),
    .req_addr(req_addr), .req_data(req_data), .prot_map(prot_map),
    .busy(busy), .done(done), .result(result), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .fl_we(fl_we), .fl_re(fl_re));

  int n_chk = 0, n_bad = 0;
  int dly_ers = 5, dly_prg = 5, dev_busy = 0, overlap = 0, done_cnt = 0;
  logic [15:0] err_inj = '0, err_bits = '0, last_cmd = '0;
  logic status_mode = 1'b0;
  logic [15:0] mem [logic [15:0]];
  logic [15:0] wa [64];
  logic [15:0] wd [64];
  int nwr = 0, nrd = 0;
  logic [15:0] first_rd = '0;
  logic [2:0] last_rc = '0;

  // Device model and bus logger, all on the falling edge
  always @(negedge clk) begin
    if (fl_we && fl_re) overlap++;
    if (done) begin done_cnt++; last_rc = result; end
    if (fl_re) begin
      if (nrd == 0) first_rd = fl_addr;
      nrd++;
      if (status_mode) fl_rdata <= {8'h00, (dev_busy == 0), 7'b0} | err_bits;
      else fl_rdata <= mem.exists(fl_addr) ? mem[fl_addr] : 16'hFFFF;
    end
    if (dev_busy > 0) dev_busy--;
    if (fl_we) begin
      if (nwr < 64) begin wa[nwr] = fl_addr; wd[nwr] = fl_wdata; end
      nwr++;
      if (last_cmd == 16'h0040) begin
        mem[fl_addr] = fl_wdata; dev_busy = dly_prg; err_bits = err_inj; status_mode = 1'b1;
      end else begin
        if (fl_wdata == 16'h00FF) status_mode = 1'b0; else status_mode = 1'b1;
        if (fl_wdata == 16'h00D0 && last_cmd == 16'h0020) dev_busy = dly_ers;
        if (fl_wdata == 16'h0050) err_bits = '0;
      end
      last_cmd = fl_wdata;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic run(input logic prog, input int f, input int l,
                     input logic [15:0] a, input logic [15:0] d);
    int start;
    @(negedge clk);
    nwr = 0; nrd = 0; dev_busy = 0; status_mode = 1'b0;
    start = done_cnt;
    req_prog = prog; req_first = SW'(f); req_last = SW'(l);
    req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 5000 && done_cnt == start; i++) @(negedge clk);
    if (done_cnt == start) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: no done, got 0 expected 1");
      summary();
    end
  endtask

  task automatic chk_wr(input string tag, input int idx, input logic [15:0] a, input logic [15:0] d);
    chk({tag, " addr"}, wa[idx], a);
    chk({tag, " data"}, wd[idx], d);
  endtask

  task automatic t_reset();
    chk("R11 reset busy", busy, 0);
    chk("R11 reset ready", req_ready, 1);
    chk("R11 reset done", done, 0);
    chk("R12 reset strobes", {fl_we, fl_re}, 0);
  endtask

  task automatic t_inval();
    run(0, 5, 2, 0, 0);
    chk("R1 result", last_rc, 1);
    chk("R1 no writes", nwr, 0);
  endtask

  task automatic t_prot();
    prot_map = 8'b0001_0000;
    run(0, 3, 5, 0, 0);
    chk("R2 result", last_rc, 2);
    chk("R2 no writes", nwr, 0);
    prot_map = 8'b1000_0000;
    dly_ers = 5;
    run(0, 1, 2, 0, 0);
    chk("R2 outside range ok", last_rc, 0);
    prot_map = '0;
  endtask

  task automatic t_erase_ok();
    dly_ers = 5;
    run(0, 1, 2, 0, 0);
    chk("R4 result", last_rc, 0);
    chk("R4 write count", nwr, 8);
    chk_wr("R3 s1 setup", 0, 16'h1000, 16'h20);
    chk_wr("R3 s1 confirm", 1, 16'h1000, 16'hD0);
    chk_wr("R4 s1 clear", 2, 16'h1000, 16'h50);
    chk_wr("R4 s1 readarr", 3, 16'h1000, 16'hFF);
    chk_wr("R3 s2 setup", 4, 16'h2000, 16'h20);
    chk_wr("R3 s2 confirm", 5, 16'h2000, 16'hD0);
    chk_wr("R4 s2 readarr", 7, 16'h2000, 16'hFF);
    chk("R3 poll address", first_rd, 16'h1000);
    chk("R3 polled more than once", (nrd >= 4) ? 1 : 0, 1);
  endtask

  task automatic t_erase_to();
    dly_ers = 1000;
    run(0, 0, 3, 0, 0);
    chk("R5 result", last_rc, 3);
    chk("R5 write count", nwr, 4);
    chk_wr("R5 suspend", 2, 16'h0000, 16'hB0);
    chk_wr("R5 readarr", 3, 16'h0000, 16'hFF);
  endtask

  task automatic t_restart();
    dly_ers = 30;
    run(0, 4, 6, 0, 0);
    chk("R10 result", last_rc, 0);
    chk("R10 all sectors", nwr, 12);
    chk_wr("R10 last sector", 11, 16'h6000, 16'hFF);
  endtask

  task automatic t_prog_ok();
    dly_prg = 5; err_inj = '0;
    run(1, 0, 0, 16'h0123, 16'h1234);
    chk("R7 result", last_rc, 0);
    chk("R7 write count", nwr, 4);
    chk("R6 precheck read addr", first_rd, 16'h0123);
    chk_wr("R7 clear", 0, 16'h0123, 16'h50);
    chk_wr("R7 setup", 1, 16'h0123, 16'h40);
    chk_wr("R7 data", 2, 16'h0123, 16'h1234);
    chk_wr("R7 readarr", 3, 16'h0123, 16'hFF);
    mem[16'h0300] = 16'h0FFF;
    run(1, 0, 0, 16'h0300, 16'h0F0F);
    chk("R6 subset accepted", last_rc, 0);
  endtask

  task automatic t_not_erased();
    mem[16'h0200] = 16'h00F0;
    run(1, 0, 0, 16'h0200, 16'h0F0F);
    chk("R6 result", last_rc, 4);
    chk("R6 no writes", nwr, 0);
  endtask

  task automatic t_prog_to();
    dly_prg = 1000;
    run(1, 0, 0, 16'h0400, 16'h0001);
    chk("R8 result", last_rc, 3);
    chk("R8 write count", nwr, 5);
    chk_wr("R8 suspend", 3, 16'h0400, 16'hB0);
    chk_wr("R8 readarr", 4, 16'h0400, 16'hFF);
    dly_prg = 5;
  endtask

  task automatic t_errors();
    err_inj = 16'h001A;
    run(1, 0, 0, 16'h0500, 16'h0001);
    chk("R9 voltage first", last_rc, 5);
    chk_wr("R9 readarr", 3, 16'h0500, 16'hFF);
    err_inj = 16'h0012;
    run(1, 0, 0, 16'h0501, 16'h0001);
    chk("R9 protect over prog", last_rc, 6);
    err_inj = 16'h0010;
    run(1, 0, 0, 16'h0502, 16'h0001);
    chk("R9 prog error", last_rc, 7);
    chk("R9 prog error write count", nwr, 4);
    err_inj = '0;
  endtask

  task automatic t_busy_ignore();
    int start, saw_ready;
    dly_ers = 10;
    @(negedge clk);
    nwr = 0; nrd = 0; dev_busy = 0; status_mode = 1'b0;
    start = done_cnt;
    req_prog = 0; req_first = 3'd0; req_last = 3'd1; req_valid = 1'b1;
    @(negedge clk);
    req_prog = 1; req_addr = 16'h0777; req_data = 16'h0000;
    saw_ready = 0;
    for (int i = 0; i < 5000 && done_cnt == start; i++) begin
      if (req_ready) saw_ready = 1;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R11 ready low while busy", saw_ready, 0);
    chk("R11 one done", done_cnt - start, 1);
    chk("R11 erase unaffected", nwr, 8);
    chk("R11 result", last_rc, 0);
    @(negedge clk);
    chk("R11 done single cycle", done, 0);
    chk("R11 idle after done", busy, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, got 0 expected 1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_inval();
    t_prot();
    t_erase_ok();
    t_erase_to();
    t_restart();
    t_prog_ok();
    t_not_erased();
    t_prog_to();
    t_errors();
    t_busy_ignore();
    chk("R12 no strobe overlap", overlap, 0);
    summary();
  end
endmodule